// File: doc/BRIEF.md
# Disk Controller Soft-Switch Latch

This block keeps the eight one-bit control levels of a floppy-style disk controller. Software never writes a data value into it. Instead, each bus access that lands in the controller's address window changes one switch. The address alone carries both the switch to change and its new level, and the bus direction plays no part. The address window is decoded outside the block, which receives only a chip-select, an access strobe and the low address bits.

The switch levels drive three stepper phase lines, a register strobe line, the motor enable, the drive select and two mode bits. The two mode bits are also brought out as a 2-bit mode code, so that a downstream data path can pick its read or write behaviour.

An access is taken once, on the clock edge where the strobe is seen rising while the chip-select is high. A stalled access that holds the strobe high does not update again. The reset input asserts asynchronously and is released through a two-stage synchronizer.

Top module: `fsw_latch`

## Requirements
- R1: While reset is held, and on leaving it, all eight switches read 0 and `mode_o` is 2'b00. This means the motor is off, the internal drive (`drv_sel_o`=0) is selected and all phases are low.
- R2: An access changes the switch whose index is `addr_i[12:10]` to the level on `addr_i[9]`. The indices map as follows: 0, 1 and 2 are the phase lines; 3 is the strobe line; 4 is the motor; 5 is the drive select; 6 is Q6; 7 is Q7. Switch i appears on `sw_o[i]`.
- R3: An access leaves the seven switches it does not address unchanged.
- R4: An access is taken at the rising clock edge where `sel_i` and `stb_i` are both 1 and `stb_i` was 0 at the previous edge. The new level is visible right after that edge and not before it.
- R5: If `stb_i` is held high over several edges, the switches change only once, even if `addr_i` changes while the strobe stays high.
- R6: A strobe rise while `sel_i` is 0 changes no switch.
- R7: `addr_i[8:0]` has no effect on which switch changes or on its new level.
- R8: `mode_o` is {Q7, Q6}, with Q7 in bit 1. The meanings are: 00 read data, 01 read status, 10 handshake, 11 write mode.
- R9: An access that sets a switch to the level it already holds leaves every output unchanged.
- R10: Pulling `rst_n` low clears the switches at once, without waiting for a clock edge. After `rst_n` rises, strobe rises seen at the first two clock edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| sel_i | input | 1 | Chip-select from the external window decoder |
| stb_i | input | 1 | Access strobe; a rise starts one access |
| addr_i | input | 13 | Low address bits: [12:10] switch index, [9] new level, [8:0] ignored |
| ph_o | output | 3 | Stepper phase lines 0..2 |
| strobe_o | output | 1 | Register strobe line (switch 3) |
| motor_o | output | 1 | Motor enable (switch 4) |
| drv_sel_o | output | 1 | Drive select, 0 internal, 1 external (switch 5) |
| q6_o | output | 1 | Mode bit Q6 (switch 6) |
| q7_o | output | 1 | Mode bit Q7 (switch 7) |
| mode_o | output | 2 | Data-path mode code {Q7, Q6} |
| sw_o | output | 8 | All eight switch levels, indexed as in R2 |

## Verification
The bench first sets each switch in turn and then clears some of them. This tells a correct index decode apart from a swapped or shifted one, and it shows whether neighbouring switches are disturbed. It then tries the following patterns:
- a strobe held high while the address moves, which separates edge-taking from level-taking;
- a rise with the chip-select low;
- the same switch reached through different low address bits;
- a repeated write of the same level;
- a reset asserted in the middle of a cycle, followed by strobes inside the synchronizer window.

A behavioural model, compared with the outputs on every clock, covers the stretches between these directed checks.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int SW_N  = 8;
  localparam int IDX_W = $clog2(SW_N);

  // switch index positions (the decode depends on them)
  localparam int SW_PH0   = 0;
  localparam int SW_PH1   = 1;
  localparam int SW_PH2   = 2;
  localparam int SW_STRB  = 3;
  localparam int SW_MOTOR = 4;
  localparam int SW_DRIVE = 5;
  localparam int SW_Q6    = 6;
  localparam int SW_Q7    = 7;

  typedef enum logic [1:0] {
    MODE_RD_DATA = 2'b00,
    MODE_RD_STAT = 2'b01,
    MODE_HSHK    = 2'b10,
    MODE_WR      = 2'b11
  } dp_mode_e;
endpackage

// File: rtl/fsw_rst_sync.sv
module fsw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/fsw_edge.sv
module fsw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic stb,
  output logic hit
);
  logic stb_q;
  logic stb_d;

  always_comb begin
    stb_d = stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign hit = sel & stb & ~stb_q;

  // R5
  hit_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/fsw_decode.sv
module fsw_decode
  import fsw_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int STEP_LSB = 9
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  output logic [SW_N-1:0]   we,
  output logic              val
);
  localparam int IDX_LSB = STEP_LSB + 1;

  logic [IDX_W-1:0] idx;
  logic             unused_low;

  assign idx        = addr[IDX_LSB +: IDX_W];
  assign val        = addr[STEP_LSB];
  // R7: bits below the step carry no meaning
  assign unused_low = ^addr[STEP_LSB-1:0];

  for (genvar i = 0; i < SW_N; i++) begin : g_we
    assign we[i] = hit && (idx == IDX_W'(i));
  end

  // R3
  always_comb begin
    we_onehot_chk: assert ($onehot0(we));
  end
endmodule

// File: rtl/fsw_bank.sv
module fsw_bank
  import fsw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_N-1:0] we,
  input  logic            val,
  output logic [SW_N-1:0] sw
);
  logic [SW_N-1:0] sw_q;
  logic [SW_N-1:0] sw_d;

  for (genvar i = 0; i < SW_N; i++) begin : g_bit
    always_comb begin
      sw_d[i] = we[i] ? val : sw_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sw_q[i] <= 1'b0;
      else if (we[i]) sw_q[i] <= sw_d[i];
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(sw_q[i]));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we[i] |=> (sw_q[i] == $past(val)));
  end

  assign sw = sw_q;
endmodule

// File: rtl/fsw_latch.sv
module fsw_latch
  import fsw_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int STEP_LSB = 9,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        ph_o,
  output logic              strobe_o,
  output logic              motor_o,
  output logic              drv_sel_o,
  output logic              q6_o,
  output logic              q7_o,
  output logic [1:0]        mode_o,
  output logic [SW_N-1:0]   sw_o
);
  logic            rst_sync_n;
  logic            hit;
  logic [SW_N-1:0] we;
  logic            val;
  logic [SW_N-1:0] sw;
  dp_mode_e        mode;

  fsw_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fsw_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .sel(sel_i), .stb(stb_i), .hit(hit));

  fsw_decode #(.ADDR_W(ADDR_W), .STEP_LSB(STEP_LSB)) u_dec (
    .hit(hit), .addr(addr_i), .we(we), .val(val));

  fsw_bank u_bank (
    .clk(clk), .rst_n(rst_sync_n), .we(we), .val(val), .sw(sw));

  assign mode      = dp_mode_e'({sw[SW_Q7], sw[SW_Q6]});
  assign ph_o      = {sw[SW_PH2], sw[SW_PH1], sw[SW_PH0]};
  assign strobe_o  = sw[SW_STRB];
  assign motor_o   = sw[SW_MOTOR];
  assign drv_sel_o = sw[SW_DRIVE];
  assign q6_o      = sw[SW_Q6];
  assign q7_o      = sw[SW_Q7];
  assign mode_o    = mode;
  assign sw_o      = sw;

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> $stable(mode_o));
  // R6
  no_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sel_i |=> $stable(sw_o));
endmodule

// File: tb/tb_fsw_latch.sv
module tb_fsw_latch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_i, stb_i;
  logic [12:0] addr_i;
  logic [2:0]  ph_o;
  logic        strobe_o, motor_o, drv_sel_o, q6_o, q7_o;
  logic [1:0]  mode_o;
  logic [7:0]  sw_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural model state
  logic [7:0] m_sw;
  logic       m_prev, m_s1, m_s2;

  always #(CLK_P/2) clk = ~clk;

  fsw_latch dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stb_i(stb_i), .addr_i(addr_i),
    .ph_o(ph_o), .strobe_o(strobe_o), .motor_o(motor_o), .drv_sel_o(drv_sel_o),
    .q6_o(q6_o), .q7_o(q7_o), .mode_o(mode_o), .sw_o(sw_o));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_sw <= '0; m_prev <= 1'b0;
    end else begin
      m_s1 <= 1'b1;
      m_s2 <= m_s1;
      if (!m_s2) begin
        m_sw <= '0; m_prev <= 1'b0;
      end else begin
        if (sel_i && stb_i && !m_prev) m_sw[int'(addr_i[12:10])] <= addr_i[9];
        m_prev <= stb_i;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-clock model comparison (R2 R3 R4 R8)
  always @(negedge clk) begin
    if (!done) begin
      check("R4 model", sw_o, m_sw);
      check("R8 model", {6'd0, mode_o}, {6'd0, m_sw[7], m_sw[6]});
      check("R2 model", {ph_o, strobe_o, motor_o, drv_sel_o, q6_o, q7_o},
            {m_sw[2:0], m_sw[3], m_sw[4], m_sw[5], m_sw[6], m_sw[7]});
    end
  end

  task automatic acc(input int idx, input int v, input int low, input bit s);
    addr_i = 13'((idx << 10) | (v << 9) | low);
    sel_i = s; stb_i = 1'b1;
    @(negedge clk);
    stb_i = 1'b0; sel_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] exp;
    rst_n = 1'b0; sel_i = 1'b0; stb_i = 1'b0; addr_i = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", sw_o, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", sw_o, 8'h00);
    check("R1 mode", {6'd0, mode_o}, 8'h00);

    // R2/R3: set each switch in turn
    exp = 8'h00;
    for (int i = 0; i < 8; i++) begin
      acc(i, 1, 1, 1'b1);
      exp[i] = 1'b1;
      check("R2 set", sw_o, exp);
    end
    check("R8 mode 11", {6'd0, mode_o}, 8'h03);

    acc(1, 0, 1, 1'b1); exp[1] = 1'b0;
    check("R3 clear ph1", sw_o, exp);
    acc(6, 0, 1, 1'b1); exp[6] = 1'b0;
    check("R8 mode 10", {6'd0, mode_o}, 8'h02);
    acc(7, 1, 1, 1'b1);
    check("R9 same level", sw_o, exp);

    // R6: no select
    acc(0, 0, 1, 1'b0);
    check("R6 no select", sw_o, exp);

    // R4: not visible before the edge
    addr_i = 13'((2 << 10) | 1); sel_i = 1'b1; stb_i = 1'b1;
    #1 check("R4 before edge", sw_o, exp);
    @(negedge clk); exp[2] = 1'b0;
    check("R4 after edge", sw_o, exp);
    stb_i = 1'b0; sel_i = 1'b0;
    @(negedge clk);

    // R5: held strobe, address moves
    addr_i = 13'((4 << 10) | 1); sel_i = 1'b1; stb_i = 1'b1;
    @(negedge clk); exp[4] = 1'b0;
    addr_i = 13'((5 << 10) | 1);
    repeat (3) @(negedge clk);
    check("R5 held strobe", sw_o, exp);
    stb_i = 1'b0; sel_i = 1'b0;
    @(negedge clk);

    // R7: low bits ignored
    acc(2, 1, 9'h1FF, 1'b1); exp[2] = 1'b1;
    check("R7 low bits ones", sw_o, exp);
    acc(2, 0, 9'h0AA, 1'b1); exp[2] = 1'b0;
    check("R7 low bits mixed", sw_o, exp);

    // R10: async reset mid-cycle, strobes in sync window ignored
    #2 rst_n = 1'b0;
    #1 check("R10 async clear", sw_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1; addr_i = 13'((4 << 10) | (1 << 9)); sel_i = 1'b1; stb_i = 1'b1;
    repeat (2) @(negedge clk);
    stb_i = 1'b0; sel_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 sync window", sw_o, 8'h00);
    acc(4, 1, 1, 1'b1);
    check("R10 after window", sw_o, 8'h10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule